// File: doc/BRIEF.md
# Raw Sensor Code to Temperature Converter

This block turns a 12-bit raw thermal-sensor code into a signed temperature in millidegrees Celsius. Each request carries a raw code and a channel number and is qualified by a valid strobe. Exactly two cycles later a registered result appears, also qualified by a valid strobe. A raw code of zero means the sensor has not produced data yet. Such a request gives no temperature and raises a no-data flag instead.

Two conversion models are available, and a static configuration input selects between them. The linear model subtracts a tenth of the code times a programmable slope from a programmable intercept. The piecewise model picks one of three fixed lines. The high line is used whenever the code is 0x500 or above. Below that threshold, channel 0 uses one line and every other channel uses a third. In both models a programmable correction term is added after the line has been evaluated. The coefficients are static inputs held by the surrounding logic.

The converter works out the segment per request. The segment is one of four: SEG_LINEAR, SEG_HIGH, SEG_LOW_CH0 and SEG_LOW_CHN. The choice moves to SEG_LINEAR whenever piecewise mode is off. In piecewise mode it moves to SEG_HIGH at or above the knee, and otherwise to SEG_LOW_CH0 or SEG_LOW_CHN depending on the channel.

Top module: `raw_temp_conv`

## Requirements
- R1: While reset is held and after its release with no request, `res_valid`, `res_nodata` and `res_temp` are all zero.
- R2: `res_valid` is high in the cycle two clock edges after `req_valid` was sampled high, and is low otherwise. Requests may arrive on back-to-back cycles.
- R3: With `cfg_piecewise` low, a nonzero code yields `cfg_offset - (raw*cfg_scale)/10 + cfg_deviation`, where the division truncates toward zero. Negative results are delivered in two's complement.
- R4: A raw code of zero yields `res_valid` high with `res_nodata` high and `res_temp` zero, in either model. A nonzero code yields `res_nodata` low.
- R5: `cfg_deviation` is added after the division and never takes part in it. It does not affect a no-data result.
- R6: With `cfg_piecewise` high and the code at or above 0x500 (1280), the result is `223000 - (1191*raw)/10 + cfg_deviation` on every channel.
- R7: With `cfg_piecewise` high, the code below 0x500 and `req_chan` equal to 0, the result is `259000 - (1452*raw)/10 + cfg_deviation`.
- R8: With `cfg_piecewise` high, the code below 0x500 and `req_chan` nonzero, the result is `276000 - (1590*raw)/10 + cfg_deviation`.
- R9: When `res_valid` is low, `res_temp` and `res_nodata` hold the value of the last result.
- R10: The product of the code and the slope never overflows, even for code 4095 with `cfg_scale` at its maximum of 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_raw | input | 12 | Raw sensor code |
| req_chan | input | 2 | Channel number of the request |
| cfg_piecewise | input | 1 | 1 selects the fixed three-segment model, 0 the linear model |
| cfg_offset | input | 32 | Linear intercept in millidegrees (signed) |
| cfg_scale | input | 11 | Linear slope in tenths of millidegrees per code |
| cfg_deviation | input | 32 | Correction added after the line (signed) |
| res_valid | output | 1 | Result strobe, two cycles after the request |
| res_nodata | output | 1 | Result carries no temperature (code was zero) |
| res_temp | output | 32 | Temperature in millidegrees (signed) |

## Verification
The hardest case is a string of back-to-back requests that each take a different segment. In that case a stale slope or intercept would slip into the wrong slot of the pipeline. The stimulus reaches it by holding `req_valid` high for consecutive cycles. Over that burst it alternates a zero code, a code at the knee and codes just below the knee on channel 0 and on a nonzero channel. Each result is then checked in its own output cycle. The knee is also probed on its own at 1279 and at 1280, and the largest code is run with the largest slope.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        SEG_LINEAR,
        SEG_HIGH,
        SEG_LOW_CH0,
        SEG_LOW_CHN
    } seg_e;

    localparam int KNEE_CODE    = 1280;
    localparam int HIGH_SLOPE   = 1191;
    localparam int HIGH_BASE    = 223000;
    localparam int LOW0_SLOPE   = 1452;
    localparam int LOW0_BASE    = 259000;
    localparam int LOWN_SLOPE   = 1590;
    localparam int LOWN_BASE    = 276000;
endpackage

// File: rtl/rtc_seg_select.sv
module rtc_seg_select
    import rtc_pkg::*;
#(
    parameter int RAW_W   = 12,
    parameter int CH_W    = 2,
    parameter int SCALE_W = 11,
    parameter int OUT_W   = 32
) (
    input  logic                    piecewise,
    input  logic [RAW_W-1:0]        raw,
    input  logic [CH_W-1:0]         chan,
    input  logic [SCALE_W-1:0]      cfg_scale,
    input  logic signed [OUT_W-1:0] cfg_offset,
    output logic [SCALE_W-1:0]      slope,
    output logic signed [OUT_W-1:0] base
);
    seg_e seg;

    // segment choice: threshold first, then channel
    always_comb begin
        if (!piecewise)
            seg = SEG_LINEAR;
        else if (int'(raw) >= KNEE_CODE)
            seg = SEG_HIGH;
        else if (chan == '0)
            seg = SEG_LOW_CH0;
        else
            seg = SEG_LOW_CHN;
    end

    always_comb begin
        unique case (seg)
            SEG_LINEAR: begin
                slope = cfg_scale;
                base  = cfg_offset;
            end
            SEG_HIGH: begin
                slope = SCALE_W'(HIGH_SLOPE);
                base  = OUT_W'(HIGH_BASE);
            end
            SEG_LOW_CH0: begin
                slope = SCALE_W'(LOW0_SLOPE);
                base  = OUT_W'(LOW0_BASE);
            end
            default: begin
                slope = SCALE_W'(LOWN_SLOPE);
                base  = OUT_W'(LOWN_BASE);
            end
        endcase
    end
endmodule

// File: rtl/rtc_mul_stage.sv
module rtc_mul_stage #(
    parameter int RAW_W   = 12,
    parameter int SCALE_W = 11,
    parameter int OUT_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [RAW_W-1:0]        raw,
    input  logic [SCALE_W-1:0]      slope,
    input  logic signed [OUT_W-1:0] base,
    output logic                    s1_valid,
    output logic                    s1_nodata,
    output logic signed [OUT_W-1:0] s1_prod,
    output logic signed [OUT_W-1:0] s1_base
);
    localparam int PROD_BITS = RAW_W + SCALE_W;

    logic signed [OUT_W-1:0] raw_ext;
    logic signed [OUT_W-1:0] slope_ext;
    logic signed [OUT_W-1:0] prod_next;

    always_comb begin
        raw_ext   = signed'(OUT_W'(raw));
        slope_ext = signed'(OUT_W'(slope));
        prod_next = raw_ext * slope_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_nodata <= 1'b0;
            s1_prod   <= '0;
            s1_base   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_nodata <= (raw == '0);
                s1_prod   <= prod_next;
                s1_base   <= base;
            end
        end
    end

    // R10: registered product stays non-negative and within the bits of code times slope
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_prod >= 0 && (s1_prod >>> PROD_BITS) == 0));
endmodule

// File: rtl/rtc_out_stage.sv
module rtc_out_stage #(
    parameter int OUT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic                    s1_nodata,
    input  logic signed [OUT_W-1:0] s1_prod,
    input  logic signed [OUT_W-1:0] s1_base,
    input  logic signed [OUT_W-1:0] cfg_deviation,
    output logic                    res_valid,
    output logic                    res_nodata,
    output logic signed [OUT_W-1:0] res_temp
);
    localparam logic signed [OUT_W-1:0] DIVISOR = OUT_W'(10);

    logic signed [OUT_W-1:0] temp_next;

    // the correction term joins only after the division
    always_comb begin
        temp_next = s1_base - (s1_prod / DIVISOR) + cfg_deviation;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_nodata <= 1'b0;
            res_temp   <= '0;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid) begin
                res_nodata <= s1_nodata;
                res_temp   <= s1_nodata ? '0 : temp_next;
            end
        end
    end

    // R4: a no-data result carries a zero temperature
    assert_nodata_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_nodata |-> (res_temp == '0));

    // R9: without a first-stage result the output holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(res_temp) && $stable(res_nodata)));
endmodule

// File: rtl/raw_temp_conv.sv
module raw_temp_conv #(
    parameter int RAW_W   = 12,
    parameter int CH_W    = 2,
    parameter int SCALE_W = 11,
    parameter int OUT_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [RAW_W-1:0]        req_raw,
    input  logic [CH_W-1:0]         req_chan,
    input  logic                    cfg_piecewise,
    input  logic signed [OUT_W-1:0] cfg_offset,
    input  logic [SCALE_W-1:0]      cfg_scale,
    input  logic signed [OUT_W-1:0] cfg_deviation,
    output logic                    res_valid,
    output logic                    res_nodata,
    output logic signed [OUT_W-1:0] res_temp
);
    logic [SCALE_W-1:0]      slope;
    logic signed [OUT_W-1:0] base;
    logic                    s1_valid;
    logic                    s1_nodata;
    logic signed [OUT_W-1:0] s1_prod;
    logic signed [OUT_W-1:0] s1_base;
    logic [1:0]              since_rst;

    rtc_seg_select #(
        .RAW_W(RAW_W), .CH_W(CH_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W)
    ) u_sel (
        .piecewise (cfg_piecewise),
        .raw       (req_raw),
        .chan      (req_chan),
        .cfg_scale (cfg_scale),
        .cfg_offset(cfg_offset),
        .slope     (slope),
        .base      (base)
    );

    rtc_mul_stage #(
        .RAW_W(RAW_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W)
    ) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .raw      (req_raw),
        .slope    (slope),
        .base     (base),
        .s1_valid (s1_valid),
        .s1_nodata(s1_nodata),
        .s1_prod  (s1_prod),
        .s1_base  (s1_base)
    );

    rtc_out_stage #(
        .OUT_W(OUT_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .s1_valid     (s1_valid),
        .s1_nodata    (s1_nodata),
        .s1_prod      (s1_prod),
        .s1_base      (s1_base),
        .cfg_deviation(cfg_deviation),
        .res_valid    (res_valid),
        .res_nodata   (res_nodata),
        .res_temp     (res_temp)
    );

    // cycles since reset, saturating, so the latency check never looks before reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    // R2: fixed two-cycle latency from request to result
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (res_valid == $past(req_valid, 2)));

    // R4: a zero code two cycles back yields no-data
    assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && $past(req_valid, 2) && $past(req_raw, 2) == '0)
            |-> res_nodata);
endmodule

// File: tb/test_raw_temp_conv.sv
module test_raw_temp_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_raw = '0;
    logic [1:0]  req_chan = '0;
    logic        cfg_piecewise = 1'b0;
    logic signed [31:0] cfg_offset = 32'sd187744;
    logic [10:0] cfg_scale = 11'd672;
    logic signed [31:0] cfg_deviation = 32'sd7000;
    logic        res_valid;
    logic        res_nodata;
    logic signed [31:0] res_temp;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    raw_temp_conv i_raw_temp_conv (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_raw(req_raw),
        .req_chan(req_chan), .cfg_piecewise(cfg_piecewise), .cfg_offset(cfg_offset),
        .cfg_scale(cfg_scale), .cfg_deviation(cfg_deviation),
        .res_valid(res_valid), .res_nodata(res_nodata), .res_temp(res_temp)
    );

    function automatic int model(input int raw, input int chan, input bit pw,
                                 input int off, input int scl, input int dev);
        int slope, base;
        if (!pw) begin slope = scl; base = off; end
        else if (raw >= 1280) begin slope = 1191; base = 223000; end
        else if (chan == 0) begin slope = 1452; base = 259000; end
        else begin slope = 1590; base = 276000; end
        return base - (raw * slope) / 10 + dev;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    // one request, result checked two edges later
    task automatic single(input string req, input int raw, input int chan);
        int exp;
        exp = (raw == 0) ? 0 : model(raw, chan, cfg_piecewise, cfg_offset, cfg_scale, cfg_deviation);
        req_valid = 1'b1; req_raw = 12'(raw); req_chan = 2'(chan);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid early"}, 32'(res_valid), 32'd0);
        @(negedge clk);
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check({req, " nodata"}, 32'(res_nodata), (raw == 0) ? 32'd1 : 32'd0);
        check({req, " temp"}, res_temp, exp);
        @(negedge clk);
        check({req, " valid drop"}, 32'(res_valid), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 valid", 32'(res_valid), 32'd0);
        check("R1 nodata", 32'(res_nodata), 32'd0);
        check("R1 temp", res_temp, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle valid", 32'(res_valid), 32'd0);
        check("R1 idle temp", res_temp, 32'd0);
    endtask

    task automatic t_linear;
        cfg_piecewise = 1'b0;
        cfg_offset = 32'sd187744; cfg_scale = 11'd672; cfg_deviation = 32'sd7000;
        single("R3 linear mid", 2000, 0);
        single("R3 linear small", 7, 3);
        cfg_offset = 32'sd217000; cfg_scale = 11'd1211; cfg_deviation = 32'sd0;
        single("R3 linear negative", 4095, 1);
    endtask

    task automatic t_deviation;
        cfg_piecewise = 1'b0;
        cfg_offset = 32'sd187744; cfg_scale = 11'd672;
        cfg_deviation = 32'sd8000;
        single("R5 deviation after division", 13, 0);
        single("R5 nodata ignores deviation", 0, 0);
    endtask

    task automatic t_zero;
        cfg_piecewise = 1'b0;
        single("R4 zero linear", 0, 2);
        cfg_piecewise = 1'b1;
        single("R4 zero piecewise", 0, 0);
    endtask

    task automatic t_piecewise;
        cfg_piecewise = 1'b1; cfg_deviation = 32'sd7000;
        single("R6 knee ch0", 1280, 0);
        single("R6 top ch3", 4095, 3);
        single("R7 below knee ch0", 1279, 0);
        single("R7 small ch0", 1, 0);
        single("R8 below knee ch1", 1279, 1);
        single("R8 mid ch2", 600, 2);
    endtask

    task automatic t_overflow;
        cfg_piecewise = 1'b0;
        cfg_offset = 32'sd0; cfg_scale = 11'd2047; cfg_deviation = 32'sd0;
        single("R10 max product", 4095, 0);
    endtask

    // back-to-back mixed segments, then hold
    task automatic t_burst;
        int raws[5] = '{0, 1280, 1279, 1279, 50};
        int chans[5] = '{1, 2, 0, 3, 0};
        int exps[5];
        bit pw = 1'b1;
        cfg_piecewise = 1'b1; cfg_deviation = -32'sd1500;
        foreach (raws[k])
            exps[k] = (raws[k] == 0) ? 0 : model(raws[k], chans[k], pw, cfg_offset, cfg_scale, cfg_deviation);
        for (int k = 0; k < 7; k++) begin
            if (k < 5) begin
                req_valid = 1'b1; req_raw = 12'(raws[k]); req_chan = 2'(chans[k]);
            end else begin
                req_valid = 1'b0;
            end
            if (k >= 2) begin
                check("R2 burst valid", 32'(res_valid), 32'd1);
                check("R2 burst nodata", 32'(res_nodata), (raws[k-2] == 0) ? 32'd1 : 32'd0);
                check("R2 burst temp", res_temp, exps[k-2]);
            end
            @(negedge clk);
        end
        // one more cycle for the last result's hold check
        check("R9 valid low", 32'(res_valid), 32'd0);
        req_raw = 12'd0; req_chan = 2'd1;
        repeat (3) @(negedge clk);
        check("R9 temp held", res_temp, exps[4]);
        check("R9 nodata held", 32'(res_nodata), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_linear();
        t_deviation();
        t_zero();
        t_piecewise();
        t_overflow();
        t_burst();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule